// File: doc/BRIEF.md
# Addressed Serial Command Front End for a Four-Channel Digital Potentiometer

This block is the serial slave front end of a four-channel digital potentiometer. It runs on the system clock and resynchronises the serial chip select, serial clock and serial data lines. It then decodes each frame that opens with chip select going low. A frame starts with an identification byte, which must carry the device type nibble, two zero bits and the two address bits set on the strap pins. An instruction byte follows. Its upper nibble is the opcode, its middle pair selects one of four preset slots, and its lower pair selects one of four channels. Both bytes arrive MSB first, and the input is sampled on the rising serial clock edge.

The opcode selects one of three frame shapes. A transfer ends with the instruction byte. A data access adds a third byte, which is either written to the bank or shifted out on the serial output on falling clock edges. A step session lasts until chip select goes high, and each serial clock pulse moves the selected wiper one position, up or down, depending on the data line. The block does not hold the wiper or preset storage. It drives single-cycle strobes together with the decoded opcode, channel, slot and data, and it reads back one data word and a write-busy flag.

Top module: `spi_pot_cmd`

## Requirements
- R1: After reset, every strobe output, `so` and `so_en` are 0.
- R2: An identification byte other than {DEV_TYPE (default 4'b0101), 2'b00, addr_strap} makes the block ignore the frame until chip select rises. No strobe is issued and `so_en` stays 0.
- R3: Instruction byte fields: opcode in bits 7:4, preset slot in bits 3:2, channel in bits 1:0. They appear on `cmd_op`, `cmd_reg` and `cmd_chan` once the byte is complete.
- R4: Opcodes 4'h1 (preset to wiper), 4'h2 (wiper to preset), 4'h3 (all presets to wipers) and 4'h4 (all wipers to presets) each raise `xfer_stb` once, at the end of the instruction byte.
- R5: Opcode 4'hA (write wiper) raises `wiper_wr_stb` once, after the third byte, with `cmd_data` equal to bits 5:0 of that byte.
- R6: Opcode 4'hC (write preset) raises `preset_wr_stb` only when chip select rises after all eight bits of the third byte. If chip select rises partway through that byte, no strobe is issued.
- R7: Opcodes 4'h9 (read wiper) and 4'hB (read preset) shift {2'b00, rd_data} out MSB first during the third byte. `so` changes on falling serial clock edges, so the master samples it on rising edges.
- R8: Opcode 4'h5 (status) shifts out {7'b0, wip}.
- R9: Opcode 4'h6 starts a step session. Every rising serial clock edge until chip select rises gives one `step_stb`, with `step_up` equal to the data line level.
- R10: Any other opcode aborts the frame. No strobe is issued and `so_en` stays 0.
- R11: `so` and `so_en` are 0 whenever the block is not in a read data phase.
- R12: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| addr_strap | input | 2 | Device address straps |
| so | output | 1 | Serial data out, 0 when not driven |
| so_en | output | 1 | Serial output drive enable |
| cmd_op | output | 4 | Latched opcode |
| cmd_reg | output | 2 | Latched preset slot |
| cmd_chan | output | 2 | Latched channel |
| cmd_data | output | DATA_W | Latched write data |
| xfer_stb | output | 1 | Transfer command strobe |
| wiper_wr_stb | output | 1 | Wiper write strobe |
| preset_wr_stb | output | 1 | Preset commit strobe |
| step_stb | output | 1 | Single wiper step strobe |
| step_up | output | 1 | Step direction, 1 = up |
| rd_data | input | DATA_W | Read word from the bank for cmd_op/cmd_chan/cmd_reg |
| wip | input | 1 | Storage write busy flag |

## Verification
The hardest cases to reach are those where chip select rises partway through the third byte of a preset write, and a commit that has to wait for chip select to rise after the data is complete. The bench drives the serial lines bit by bit and can stop a frame after any bit count. It checks the commit counter once with chip select still low and again after the rise. Step sessions use mixed data levels on consecutive pulses, and the bench counts the up and down steps separately.

// File: rtl/spi_pot_cmd_pkg.sv
package spi_pot_cmd_pkg;
   typedef enum logic [3:0] {
      OP_P2W    = 4'h1,
      OP_W2P    = 4'h2,
      OP_GP2W   = 4'h3,
      OP_GW2P   = 4'h4,
      OP_STAT   = 4'h5,
      OP_STEP   = 4'h6,
      OP_RD_W   = 4'h9,
      OP_WR_W   = 4'hA,
      OP_RD_P   = 4'hB,
      OP_WR_P   = 4'hC
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ID, ST_INSTR, ST_WR, ST_RD, ST_STEP, ST_DONE, ST_IGNORE
   } st_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_pot_byte_rx.sv
module spi_pot_byte_rx #(
   parameter int unsigned BITS = 8,
   localparam int unsigned CW = $clog2(BITS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            sample,
   input  logic            bit_in,
   output logic            done,
   output logic [BITS-1:0] data
);
   logic [CW-1:0]   cnt;
   logic [BITS-2:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (sample) begin
         cnt <= (cnt == CW'(BITS-1)) ? '0 : cnt + 1'b1;
         sh  <= {sh[BITS-3:0], bit_in};
      end
   end

   assign done = sample && (cnt == CW'(BITS-1));
   assign data = {sh, bit_in};
endmodule

// File: rtl/spi_pot_cmd.sv
module spi_pot_cmd
   import spi_pot_cmd_pkg::*;
#(
   parameter logic [3:0]  DEV_TYPE    = 4'b0101,
   parameter int unsigned DATA_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic [1:0]        addr_strap,
   output logic              so,
   output logic              so_en,
   output logic [3:0]        cmd_op,
   output logic [1:0]        cmd_reg,
   output logic [1:0]        cmd_chan,
   output logic [DATA_W-1:0] cmd_data,
   output logic              xfer_stb,
   output logic              wiper_wr_stb,
   output logic              preset_wr_stb,
   output logic              step_stb,
   output logic              step_up,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              wip
);
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned PAD_W  = BYTE_W - DATA_W;

   generate
      if (DATA_W < 1 || DATA_W > 7) begin : g_bad_w
         $error("DATA_W must be between 1 and 7");
      end
   endgenerate

   logic [2:0] raw, syn;
   logic       cs_lvl, sck_lvl, si_lvl, sck_q, cs_q;
   logic       sck_rise, sck_fall, cs_rise;
   logic       byte_done;
   logic [BYTE_W-1:0] rx_byte;
   st_e        st;
   logic       pend, rd_first;
   logic [BYTE_W-1:0] tx;

   assign raw = {cs_n, sck, si};

   spi_pot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   assign cs_lvl  = syn[2];
   assign sck_lvl = syn[1];
   assign si_lvl  = syn[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_lvl;
         cs_q  <= cs_lvl;
      end
   end

   assign sck_rise = sck_lvl && !sck_q;
   assign sck_fall = !sck_lvl && sck_q;
   assign cs_rise  = cs_lvl && !cs_q;

   spi_pot_byte_rx #(.BITS(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(cs_lvl),
      .sample(sck_rise && !cs_lvl), .bit_in(si_lvl),
      .done(byte_done), .data(rx_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         pend          <= 1'b0;
         rd_first      <= 1'b0;
         tx            <= '0;
         cmd_op        <= '0;
         cmd_reg       <= '0;
         cmd_chan      <= '0;
         cmd_data      <= '0;
         xfer_stb      <= 1'b0;
         wiper_wr_stb  <= 1'b0;
         preset_wr_stb <= 1'b0;
         step_stb      <= 1'b0;
         step_up       <= 1'b0;
      end else begin
         xfer_stb      <= 1'b0;
         wiper_wr_stb  <= 1'b0;
         preset_wr_stb <= 1'b0;
         step_stb      <= 1'b0;
         if (cs_lvl) begin
            st <= ST_IDLE;
            tx <= '0;
            if (cs_rise && pend) preset_wr_stb <= 1'b1;
            pend <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: st <= ST_ID;
               ST_ID: if (byte_done) begin
                  if (rx_byte[7:4] == DEV_TYPE && rx_byte[3:2] == 2'b00 &&
                      rx_byte[1:0] == addr_strap)
                     st <= ST_INSTR;
                  else
                     st <= ST_IGNORE;
               end
               ST_INSTR: if (byte_done) begin
                  cmd_op   <= rx_byte[7:4];
                  cmd_reg  <= rx_byte[3:2];
                  cmd_chan <= rx_byte[1:0];
                  case (rx_byte[7:4])
                     OP_P2W, OP_W2P, OP_GP2W, OP_GW2P: begin
                        xfer_stb <= 1'b1;
                        st       <= ST_DONE;
                     end
                     OP_RD_W, OP_RD_P, OP_STAT: begin
                        rd_first <= 1'b1;
                        st       <= ST_RD;
                     end
                     OP_WR_W, OP_WR_P: st <= ST_WR;
                     OP_STEP:          st <= ST_STEP;
                     default:          st <= ST_IGNORE;
                  endcase
               end
               ST_WR: if (byte_done) begin
                  cmd_data <= rx_byte[DATA_W-1:0];
                  if (cmd_op == OP_WR_W) wiper_wr_stb <= 1'b1;
                  else                   pend         <= 1'b1;
                  st <= ST_DONE;
               end
               ST_RD: if (sck_fall) begin
                  rd_first <= 1'b0;
                  if (rd_first)
                     tx <= (cmd_op == OP_STAT) ? {{(BYTE_W-1){1'b0}}, wip}
                                               : {{PAD_W{1'b0}}, rd_data};
                  else
                     tx <= {tx[BYTE_W-2:0], 1'b0};
               end
               ST_STEP: if (sck_rise) begin
                  step_stb <= 1'b1;
                  step_up  <= si_lvl;
               end
               default: ;
            endcase
         end
      end
   end

   assign so_en = (st == ST_RD);
   assign so    = so_en && tx[BYTE_W-1];
endmodule

// File: rtl/spi_pot_cmd_chk.sv
module spi_pot_cmd_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_lvl,
   input logic       so,
   input logic       so_en,
   input logic [3:0] cmd_op,
   input logic       xfer_stb,
   input logic       wiper_wr_stb,
   input logic       preset_wr_stb,
   input logic       step_stb
);
   assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_stb, wiper_wr_stb, preset_wr_stb, step_stb}));

   assert_xfer_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb |=> !xfer_stb);

   assert_wwr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wiper_wr_stb |=> !wiper_wr_stb);

   assert_commit_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      preset_wr_stb |-> cs_lvl);

   assert_idle_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> (!so_en && !so));

   assert_xfer_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb |-> (cmd_op >= 4'h1 && cmd_op <= 4'h4));

   assert_step_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_stb |-> (cmd_op == 4'h6 && !cs_lvl));
endmodule

bind spi_pot_cmd spi_pot_cmd_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .so(so), .so_en(so_en),
   .cmd_op(cmd_op), .xfer_stb(xfer_stb), .wiper_wr_stb(wiper_wr_stb),
   .preset_wr_stb(preset_wr_stb), .step_stb(step_stb));

// File: tb/spi_pot_cmd_tb.sv
`timescale 1ns/1ps
module spi_pot_cmd_tb_top;
   localparam int HALF = 8;
   localparam logic [1:0] STRAP = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic so, so_en;
   logic [3:0] cmd_op;
   logic [1:0] cmd_reg, cmd_chan;
   logic [5:0] cmd_data;
   logic xfer_stb, wiper_wr_stb, preset_wr_stb, step_stb, step_up;
   logic [5:0] rd_data;
   logic wip = 1'b0;

   logic [5:0] bank_w [4];
   logic [5:0] bank_p [4][4];

   int n_chk = 0, n_fail = 0;
   int n_xfer = 0, n_wwr = 0, n_pwr = 0, n_step = 0, n_up = 0;
   logic [5:0] last_data;
   bit finished = 0;

   always #10 clk = ~clk;

   spi_pot_cmd dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .addr_strap(STRAP), .so(so), .so_en(so_en), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
      .xfer_stb(xfer_stb), .wiper_wr_stb(wiper_wr_stb),
      .preset_wr_stb(preset_wr_stb), .step_stb(step_stb), .step_up(step_up),
      .rd_data(rd_data), .wip(wip));

   assign rd_data = (cmd_op == 4'h9) ? bank_w[cmd_chan] : bank_p[cmd_chan][cmd_reg];

   always @(posedge clk) begin
      if (xfer_stb) n_xfer <= n_xfer + 1;
      if (wiper_wr_stb) begin n_wwr <= n_wwr + 1; last_data <= cmd_data; end
      if (preset_wr_stb) begin n_pwr <= n_pwr + 1; last_data <= cmd_data; end
      if (step_stb) begin
         n_step <= n_step + 1;
         if (step_up) n_up <= n_up + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_high();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(3 * HALF);
   endtask

   task automatic send_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         si = tx[i];
         wait_clk(HALF);
         rx[i] = so;
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic header(input logic [3:0] op, input logic [1:0] rg, input logic [1:0] ch);
      logic [7:0] d;
      send_bits({4'b0101, 2'b00, STRAP}, 8, d);
      send_bits({op, rg, ch}, 8, d);
   endtask

   task automatic t_reset();
      check(!xfer_stb && !wiper_wr_stb && !preset_wr_stb && !step_stb, "R1 strobes", 0, 0);
      check(!so && !so_en, "R1 so", {so, so_en}, 0);
   endtask

   task automatic t_id_mismatch();
      logic [7:0] d;
      int x0 = n_xfer;
      cs_low();
      send_bits({4'b0101, 2'b00, 2'b01}, 8, d);
      send_bits({4'h1, 2'b00, 2'b00}, 8, d);
      cs_high();
      check(n_xfer == x0, "R2 addr mismatch", n_xfer - x0, 0);
      cs_low();
      send_bits({4'b0111, 2'b00, STRAP}, 8, d);
      send_bits({4'h9, 2'b00, 2'b00}, 8, d);
      check(!so_en, "R2 type mismatch so_en", so_en, 0);
      cs_high();
      check(n_xfer == x0, "R2 type mismatch", n_xfer - x0, 0);
   endtask

   task automatic t_xfer();
      for (int op = 1; op <= 4; op++) begin
         int x0 = n_xfer;
         cs_low();
         header(op[3:0], 2'(op - 1), 2'(3 - op));
         wait_clk(HALF);
         check(n_xfer == x0 + 1, "R4 xfer count", n_xfer - x0, 1);
         check(cmd_op == op[3:0] && cmd_reg == 2'(op - 1) && cmd_chan == 2'(3 - op),
               "R3 fields", {cmd_op, cmd_reg, cmd_chan}, {op[3:0], 2'(op - 1), 2'(3 - op)});
         cs_high();
      end
   endtask

   task automatic t_wr_wiper();
      logic [7:0] d;
      int w0 = n_wwr;
      cs_low();
      header(4'hA, 2'b00, 2'b01);
      send_bits({2'b00, 6'h2D}, 8, d);
      wait_clk(HALF);
      check(n_wwr == w0 + 1, "R5 wiper write count", n_wwr - w0, 1);
      check(last_data == 6'h2D, "R5 wiper data", last_data, 6'h2D);
      cs_high();
   endtask

   task automatic t_wr_preset();
      logic [7:0] d;
      int p0 = n_pwr;
      cs_low();
      header(4'hC, 2'b10, 2'b11);
      send_bits({2'b00, 6'h13}, 8, d);
      wait_clk(HALF);
      check(n_pwr == p0, "R6 no commit before deselect", n_pwr - p0, 0);
      cs_high();
      check(n_pwr == p0 + 1, "R6 commit on deselect", n_pwr - p0, 1);
      check(last_data == 6'h13, "R6 commit data", last_data, 6'h13);
      cs_low();
      header(4'hC, 2'b01, 2'b00);
      send_bits({2'b00, 6'h3F}, 4, d);
      cs_high();
      check(n_pwr == p0 + 1, "R6 partial byte discarded", n_pwr - p0, 1);
   endtask

   task automatic t_read(input logic [3:0] op, input logic [1:0] rg, input logic [1:0] ch,
                         input logic [7:0] exp, input string tag);
      logic [7:0] d;
      cs_low();
      header(op, rg, ch);
      send_bits(8'h00, 8, d);
      check(d == exp, tag, d, exp);
      cs_high();
      check(!so_en && !so, "R11 released after read", {so_en, so}, 0);
   endtask

   task automatic t_step();
      logic [7:0] d;
      int s0 = n_step, u0 = n_up;
      cs_low();
      header(4'h6, 2'b00, 2'b10);
      send_bits(8'b1101_0110, 8, d);
      send_bits(8'b1110_0000, 3, d);
      wait_clk(HALF);
      check(n_step == s0 + 11, "R9 step count", n_step - s0, 11);
      check(n_up == u0 + 8, "R9 up count", n_up - u0, 8);
      cs_high();
      send_bits(8'hFF, 4, d);
      check(n_step == s0 + 11, "R9 no steps after deselect", n_step - s0, 11);
   endtask

   task automatic t_bad_op();
      logic [7:0] d;
      int x0 = n_xfer, w0 = n_wwr, p0 = n_pwr, s0 = n_step;
      cs_low();
      header(4'hF, 2'b00, 2'b00);
      send_bits(8'hA5, 8, d);
      check(!so_en && d == 8'h00, "R10 no output on bad op", d, 0);
      cs_high();
      check(n_xfer == x0 && n_wwr == w0 && n_pwr == p0 && n_step == s0,
            "R10 no strobes", n_xfer + n_wwr + n_pwr + n_step, x0 + w0 + p0 + s0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 4; c++) begin
         bank_w[c] = 6'(5 * c + 7);
         for (int r = 0; r < 4; r++) bank_p[c][r] = 6'(9 * c + 4 * r + 33);
      end
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_id_mismatch();
      t_xfer();
      t_wr_wiper();
      t_wr_preset();
      t_read(4'h9, 2'b00, 2'b10, {2'b00, bank_w[2]}, "R7 read wiper");
      t_read(4'hB, 2'b11, 2'b01, {2'b00, bank_p[1][3]}, "R7 read preset");
      wip = 1'b1;
      t_read(4'h5, 2'b00, 2'b00, 8'h01, "R8 status busy");
      wip = 1'b0;
      t_read(4'h5, 2'b00, 2'b00, 8'h00, "R8 status idle");
      t_step();
      t_bad_op();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end
endmodule